// File: doc/BRIEF.md
# Single-Byte Serial Flash Access Engine

This block gives software byte-at-a-time access to a serial NOR flash through a small byte-wide register bus. Software first loads a 32-bit flash address into four address byte registers. It then writes a command code into the command register. The engine runs one chip-select frame on a single-line SPI link (mode 0). A read frame captures one byte into a read-data register. A program frame sends the byte held in the write-data register.

At the end of every frame the address register steps forward by one. Software can therefore stream through consecutive bytes by writing the command code again, without reloading the address. The command register reads back the code it holds while the frame runs and returns zero once the frame is done, so software polls it for completion.

A configuration bit chooses between the plain read opcode and the fast-read opcode. Fast read adds eight dummy clocks between the address and the data. Only the low 24 address bits go out on the wire. The address counter itself is 32 bits wide and wraps to zero.

Top module: `nor_pio_byte_access`

## Requirements
- R1: After reset, every register reads 0, `spi_cs_n` is 1, and `spi_sclk` and `spi_mosi` are 0.
- R2: Writing 0x81 to the command register (offset 0) runs a read frame. The frame sends opcode 0x03, then address bits 23..0, MSB first. It then clocks in 8 bits, MSB first, and stores them in the read-data register (offset 6). Frames use mode 0: `spi_sclk` idles low, `spi_miso` is sampled on the rising edge, and `spi_mosi` changes only while `spi_sclk` is low.
- R3: When bit 0 of the configuration register (offset 7) is 1, a read frame sends opcode 0x0B and adds 8 dummy clocks after the address. The frame is then 48 clocks long instead of 40.
- R4: Writing 0x90 to the command register runs a 40-clock program frame. The frame sends opcode 0x02, address bits 23..0, and then the byte in the write-data register (offset 5).
- R5: The command register reads back the accepted code while a frame runs. It reads 0 from the clock edge that follows the end of the last clock high phase. That edge is 1 + 2·HALF_DIV·N clock edges after the edge that wrote the command, where N is 40 or 48.
- R6: After each frame completes, the 32-bit address (offsets 1..4, low byte first) increases by 1 modulo 2^32.
- R7: A value written to the command register other than 0x81 or 0x90 is ignored: the command register stays 0 and no frame starts.
- R8: While a frame is running, bus writes to any register are ignored. This covers the address, write-data, configuration and command registers.
- R9: `spi_cs_n` is low for exactly one frame, and `spi_sclk` pulses only while `spi_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from bus_addr) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A command written at clock edge k must leave the command register reading zero exactly 1 + 2·HALF_DIV·N edges later. N is 40 for a plain read or a program, and 48 for a fast read. After issuing a command, the bench samples the command register on every falling edge. It counts the edges until the register reads zero and compares that count with the formula.

The read-data register, the address registers and the flash model's captured frame are all stable once the command register is clear. The bench reads them only after that point. An illegal command code would show up by the falling edge after its write. The bench therefore checks the command register at that edge, and checks chip select one edge later.

// File: rtl/nor_pio_pkg.sv
package nor_pio_pkg;

  localparam logic [7:0] CMD_PIO_RD = 8'h81;
  localparam logic [7:0] CMD_PIO_WR = 8'h90;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PROG = 8'h02;

  localparam int FRAME_W = 48;
  localparam int CNT_W   = 6;

  localparam logic [CNT_W-1:0] BITS_PLAIN = 6'd40;
  localparam logic [CNT_W-1:0] BITS_FAST  = 6'd48;

  typedef enum logic [3:0] {
    RA_CMD   = 4'd0,
    RA_ADR0  = 4'd1,
    RA_ADR1  = 4'd2,
    RA_ADR2  = 4'd3,
    RA_ADR3  = 4'd4,
    RA_WDATA = 4'd5,
    RA_RDATA = 4'd6,
    RA_CFG   = 4'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

endpackage

// File: rtl/nor_pio_regs.sv
module nor_pio_regs
  import nor_pio_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              frame_done,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        cmd,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        wr_byte,
  output logic              fast_rd
);

  localparam int NBYTES = ADDR_W / 8;

  logic [7:0]        cmd_q,   cmd_n;
  logic [ADDR_W-1:0] addr_q,  addr_n;
  logic [7:0]        wdata_q, wdata_n;
  logic [7:0]        rdata_q, rdata_n;
  logic              fast_q,  fast_n;
  logic              busy;
  logic              wr_ok;

  assign busy  = (cmd_q != 8'h00);
  assign wr_ok = bus_wr && !busy;

  // command register: legal codes only, cleared when the frame ends
  always_comb begin
    cmd_n = cmd_q;
    if (frame_done) begin
      cmd_n = 8'h00;
    end else if (wr_ok && bus_addr == RA_CMD &&
                 (bus_wdata == CMD_PIO_RD || bus_wdata == CMD_PIO_WR)) begin
      cmd_n = bus_wdata;
    end
  end

  // address counter with byte write lanes
  always_comb begin
    addr_n = addr_q;
    if (frame_done) begin
      addr_n = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
    end else if (wr_ok) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (bus_addr == 4'(int'(RA_ADR0) + b)) begin
          addr_n[b*8 +: 8] = bus_wdata;
        end
      end
    end
  end

  always_comb begin
    wdata_n = wdata_q;
    fast_n  = fast_q;
    rdata_n = rdata_q;
    if (wr_ok && bus_addr == RA_WDATA) wdata_n = bus_wdata;
    if (wr_ok && bus_addr == RA_CFG)   fast_n  = bus_wdata[0];
    if (frame_done && cmd_q == CMD_PIO_RD) rdata_n = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      addr_q  <= '0;
      wdata_q <= 8'h00;
      rdata_q <= 8'h00;
      fast_q  <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      rdata_q <= rdata_n;
      fast_q  <= fast_n;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (reg_addr_e'(bus_addr))
      RA_CMD:   bus_rdata = cmd_q;
      RA_ADR0:  bus_rdata = addr_q[7:0];
      RA_ADR1:  bus_rdata = addr_q[15:8];
      RA_ADR2:  bus_rdata = addr_q[23:16];
      RA_ADR3:  bus_rdata = addr_q[31:24];
      RA_WDATA: bus_rdata = wdata_q;
      RA_RDATA: bus_rdata = rdata_q;
      RA_CFG:   bus_rdata = {7'h00, fast_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign cmd        = cmd_q;
  assign flash_addr = addr_q;
  assign wr_byte    = wdata_q;
  assign fast_rd    = fast_q;

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> addr_q == $past(addr_q) + {{(ADDR_W-1){1'b0}}, 1'b1});

  p_busy_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done && bus_wr) |=>
      (addr_q == $past(addr_q) && wdata_q == $past(wdata_q) &&
       fast_q == $past(fast_q) && cmd_q == $past(cmd_q)));

  p_cmd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> cmd_q == 8'h00);

endmodule

// File: rtl/nor_pio_frame.sv
module nor_pio_frame
  import nor_pio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cmd,
  input  logic               fast_rd,
  input  logic [23:0]        addr_lo,
  input  logic [7:0]         wr_byte,
  input  logic               frame_done,
  output logic               start,
  output logic [FRAME_W-1:0] tx_bits,
  output logic [CNT_W-1:0]   n_bits
);

  logic run_q, run_n;

  assign start = !run_q && (cmd != 8'h00);

  always_comb begin
    run_n = run_q;
    if (start)           run_n = 1'b1;
    else if (frame_done) run_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_n;
  end

  // frame image, MSB first; trailing bits are don't-care while data comes in
  always_comb begin
    tx_bits = '0;
    n_bits  = BITS_PLAIN;
    if (cmd == CMD_PIO_WR) begin
      tx_bits = {OP_PROG, addr_lo, wr_byte, 8'h00};
    end else if (fast_rd) begin
      tx_bits = {OP_FAST, addr_lo, 16'h0000};
      n_bits  = BITS_FAST;
    end else begin
      tx_bits = {OP_READ, addr_lo, 16'h0000};
    end
  end

  p_done_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> run_q);

endmodule

// File: rtl/nor_pio_phy.sv
module nor_pio_phy
  import nor_pio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_bits,
  input  logic [CNT_W-1:0]   n_bits,
  output logic               frame_done,
  output logic [7:0]         rx_byte,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(HALF_DIV - 1);

  phase_e             ph_q,  ph_n;
  logic [DIV_W-1:0]   div_q, div_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] sh_q,  sh_n;
  logic [7:0]         rx_q,  rx_n;
  logic               tick;

  assign tick = (div_q == DIV_TOP);

  always_comb begin
    ph_n  = ph_q;
    div_n = div_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    rx_n  = rx_q;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_n  = PH_LOW;
          div_n = '0;
          cnt_n = n_bits;
          sh_n  = tx_bits;
        end
      end
      PH_LOW: begin
        if (tick) begin
          ph_n  = PH_HIGH;
          div_n = '0;
          rx_n  = {rx_q[6:0], spi_miso};
        end else begin
          div_n = div_q + DIV_W'(1);
        end
      end
      PH_HIGH: begin
        if (tick) begin
          div_n = '0;
          sh_n  = {sh_q[FRAME_W-2:0], 1'b0};
          cnt_n = cnt_q - CNT_W'(1);
          ph_n  = (cnt_q == CNT_W'(1)) ? PH_IDLE : PH_LOW;
        end else begin
          div_n = div_q + DIV_W'(1);
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      div_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
      rx_q  <= 8'h00;
    end else begin
      ph_q  <= ph_n;
      div_q <= div_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      rx_q  <= rx_n;
    end
  end

  assign frame_done = (ph_q == PH_HIGH) && tick && (cnt_q == CNT_W'(1));
  assign rx_byte    = rx_q;
  assign spi_sclk   = (ph_q == PH_HIGH);
  assign spi_cs_n   = (ph_q == PH_IDLE);
  assign spi_mosi   = (ph_q != PH_IDLE) && sh_q[FRAME_W-1];

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && !frame_done && !tick) |=> $stable(spi_mosi));

endmodule

// File: rtl/nor_pio_byte_access.sv
module nor_pio_byte_access
  import nor_pio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  logic               rst_meta, rst_sync_n;
  logic [7:0]         cmd;
  logic [ADDR_W-1:0]  flash_addr;
  logic [7:0]         wr_byte;
  logic               fast_rd;
  logic               start;
  logic               frame_done;
  logic [7:0]         rx_byte;
  logic [FRAME_W-1:0] tx_bits;
  logic [CNT_W-1:0]   n_bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  nor_pio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .cmd        (cmd),
    .flash_addr (flash_addr),
    .wr_byte    (wr_byte),
    .fast_rd    (fast_rd)
  );

  nor_pio_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd        (cmd),
    .fast_rd    (fast_rd),
    .addr_lo    (flash_addr[23:0]),
    .wr_byte    (wr_byte),
    .frame_done (frame_done),
    .start      (start),
    .tx_bits    (tx_bits),
    .n_bits     (n_bits)
  );

  nor_pio_phy #(.HALF_DIV(HALF_DIV)) u_phy (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .tx_bits    (tx_bits),
    .n_bits     (n_bits),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso)
  );

endmodule

// File: tb/sim_nor_pio_byte_access.sv
`timescale 1ns/1ps
module sim_nor_pio_byte_access;

  localparam int HALF = 2;
  localparam int LAT_PLAIN = 1 + 2*HALF*40;
  localparam int LAT_FAST  = 1 + 2*HALF*48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  nor_pio_byte_access #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // flash model: 256 bytes indexed by address bits 7..0
  logic [7:0]  mem [256];
  int          bc;
  int          last_bits;
  logic [7:0]  m_op;
  logic [23:0] m_adr;
  logic [7:0]  m_wd;

  always @(negedge spi_cs_n) bc = 0;

  always @(posedge spi_sclk) begin
    if (bc < 8)       m_op  = {m_op[6:0], spi_mosi};
    else if (bc < 32) m_adr = {m_adr[22:0], spi_mosi};
    else if (bc < 40) m_wd  = {m_wd[6:0], spi_mosi};
    bc++;
  end

  always @(negedge spi_sclk) begin
    int hdr;
    hdr = (m_op == 8'h0B) ? 40 : 32;
    if (!spi_cs_n && bc >= hdr && bc < hdr + 8)
      spi_miso = mem[m_adr[7:0]][7 - (bc - hdr)];
  end

  always @(posedge spi_cs_n) begin
    last_bits = bc;
    if (m_op == 8'h02 && bc == 40) mem[m_adr[7:0]] = m_wd;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    for (int b = 0; b < 4; b++) bwr(4'(1 + b), a[b*8 +: 8]);
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      brd(4'(1 + b), d);
      a[b*8 +: 8] = d;
    end
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] d;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      brd(4'd0, d);
      if (d == 8'h00) break;
    end
  endtask

  task automatic run_cmd(input logic [7:0] c, output int n);
    bwr(4'd0, c);
    wait_idle(n);
  endtask

  initial begin
    logic [31:0] a32, exp_a;
    logic [7:0]  d;
    logic [7:0]  wvals [16];
    int          n;

    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    spi_miso = 1'b0; bc = 0; last_bits = 0;
    m_op = 8'h00; m_adr = 24'h0; m_wd = 8'h00;
    bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      brd(4'(r), d);
      chk($sformatf("R1 reg %0d after reset", r), {24'h0, d}, 32'h0);
    end
    chk("R1 cs_n idle", {31'h0, spi_cs_n}, 32'h1);
    chk("R1 sclk idle", {31'h0, spi_sclk}, 32'h0);
    chk("R1 mosi idle", {31'h0, spi_mosi}, 32'h0);

    // R2/R5/R6/R9: plain reads streamed across a byte carry
    set_addr(32'h00ABCDF0);
    for (int i = 0; i < 24; i++) begin
      exp_a = 32'h00ABCDF0 + 32'(i);
      run_cmd(8'h81, n);
      chk("R5 plain read latency", 32'(n), 32'(LAT_PLAIN));
      chk("R2 read opcode", {24'h0, m_op}, 32'h03);
      chk("R2 address on wire", {8'h0, m_adr}, {8'h0, exp_a[23:0]});
      brd(4'd6, d);
      chk("R2 captured byte", {24'h0, d}, {24'h0, mem[exp_a[7:0]]});
      chk("R9 frame clocks", 32'(last_bits), 32'd40);
      chk("R9 idle after frame", {30'h0, spi_cs_n, spi_sclk}, 32'h2);
    end
    get_addr(a32);
    chk("R6 address after stream", a32, 32'h00ABCE08);

    // R3/R6: fast reads across the 2^32 wrap
    bwr(4'd7, 8'h01);
    set_addr(32'hFFFFFFF8);
    for (int i = 0; i < 16; i++) begin
      exp_a = 32'hFFFFFFF8 + 32'(i);
      run_cmd(8'h81, n);
      chk("R5 fast read latency", 32'(n), 32'(LAT_FAST));
      chk("R3 fast opcode", {24'h0, m_op}, 32'h0B);
      chk("R3 fast frame clocks", 32'(last_bits), 32'd48);
      chk("R3 address on wire", {8'h0, m_adr}, {8'h0, exp_a[23:0]});
      brd(4'd6, d);
      chk("R3 captured byte", {24'h0, d}, {24'h0, mem[exp_a[7:0]]});
    end
    get_addr(a32);
    chk("R6 address wrapped", a32, 32'h00000008);

    // R4: program stream, then read back without reloading in between
    bwr(4'd7, 8'h00);
    set_addr(32'h00001040);
    for (int i = 0; i < 16; i++) begin
      wvals[i] = 8'((i * 53 + 7) & 255);
      bwr(4'd5, wvals[i]);
      run_cmd(8'h90, n);
      chk("R5 program latency", 32'(n), 32'(LAT_PLAIN));
      chk("R4 program opcode", {24'h0, m_op}, 32'h02);
      chk("R4 address on wire", {8'h0, m_adr}, 32'h00001040 + 32'(i));
      chk("R4 byte programmed", {24'h0, mem[8'(8'h40 + i)]}, {24'h0, wvals[i]});
    end
    get_addr(a32);
    chk("R6 address after program", a32, 32'h00001050);
    set_addr(32'h00001040);
    for (int i = 0; i < 16; i++) begin
      run_cmd(8'h81, n);
      brd(4'd6, d);
      chk("R2 readback of programmed", {24'h0, d}, {24'h0, wvals[i]});
    end

    // R7: every other command code is ignored
    for (int v = 0; v < 256; v++) begin
      if (v == 8'h81 || v == 8'h90) continue;
      bwr(4'd0, 8'(v));
      brd(4'd0, d);
      chk($sformatf("R7 code %02h ignored", v), {24'h0, d}, 32'h0);
      @(negedge clk);
      chk($sformatf("R7 code %02h no frame", v), {31'h0, spi_cs_n}, 32'h1);
    end

    // R8: writes during a frame are ignored
    bwr(4'd5, 8'h3C);
    set_addr(32'h00000200);
    bwr(4'd0, 8'h81);
    bwr(4'd1, 8'h55);
    bwr(4'd5, 8'hEE);
    bwr(4'd0, 8'h90);
    bwr(4'd7, 8'h01);
    wait_idle(n);
    get_addr(a32);
    chk("R8 address untouched while busy", a32, 32'h00000201);
    brd(4'd5, d);
    chk("R8 write data untouched", {24'h0, d}, 32'h3C);
    brd(4'd7, d);
    chk("R8 config untouched", {24'h0, d}, 32'h0);
    chk("R8 frame stayed plain read", {24'h0, m_op}, 32'h03);
    brd(4'd6, d);
    chk("R8 read data from frame", {24'h0, d}, {24'h0, mem[8'h00]});
    repeat (5) @(negedge clk);
    chk("R8 no second frame", {31'h0, spi_cs_n}, 32'h1);
    brd(4'd0, d);
    chk("R8 command idle", {24'h0, d}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule